// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Register

This block merges five reset requests into one synchronous system reset. The requests are an active-low external reset pin, a missing-clock timeout, a comparator output, a watchdog expiry and a flash access fault. The pin is asynchronous, so it passes through a synchronizer. The other four requests arrive as synchronous digital levels or pulses. When a request is accepted, the system reset goes low for a minimum number of cycles. It then rises on a clock edge.

A single 8-bit register serves two purposes:

- **Reading** returns the cause of the last reset, as one flag. The flag becomes visible when the reset ends.
- **Writing** arms or disarms the two optional sources: the missing-clock detector and the comparator.

The comparator's arming is dropped by every reset, so software re-arms it once the comparator has settled. The block never drives the external pin; it only samples it. The block also supplies the watchdog's time base. This is a one-cycle tick at one twelfth of the clock rate. The tick restarts from zero after every reset.

Top module: `rstc_top`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n` goes low on the third rising clock edge after the fall. It stays low until the third edge after the pin returns high, and for at least 16 cycles. After release, `reg_rdata` reads 0x01 (bit 0 = pin cause).
- R2: A write with `reg_wr` high sets the missing-clock enable from `reg_wdata` bit 2 and the comparator enable from bit 5. Writes never change the cause flags and are ignored while `sys_rst_n` is low. While its enable is 0, `mcd_timeout` causes no reset.
- R3: When enabled, `mcd_timeout` high starts a reset on the next rising edge. Afterwards `reg_rdata` reads 0x04 (bit 2). The missing-clock enable is kept across resets other than power-on.
- R4: When the comparator is enabled, `cmp_ok` low (non-inverting input below inverting) starts a reset. Afterwards `reg_rdata` reads 0x20 (bit 5).
- R5: Every reset, of any cause, clears the comparator enable. A later `cmp_ok` low causes no reset until software writes bit 5 again.
- R6: `wdt_expire` high starts a reset. Afterwards `reg_rdata` reads 0x08 (bit 3).
- R7: `flash_fault` high starts a reset. Afterwards `reg_rdata` reads 0x40 (bit 6).
- R8: An internal request holds `sys_rst_n` low for exactly 16 cycles, released on a rising edge. Requests that arrive while the reset is active neither extend it nor change its cause.
- R9: At most one flag is ever set in `reg_rdata`. All flags read 0 while the reset is active. For simultaneous requests the priority is pin, missing-clock, comparator, watchdog, flash.
- R10: `wdt_tick` is low during reset. It first pulses in the 12th cycle after release, and then every 12 cycles.
- R11: While `por_n` is low, `sys_rst_n` is low, both enables are 0 and `reg_rdata` is 0x00. `sys_rst_n` rises on the 16th rising edge after `por_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| mcd_timeout | input | 1 | Missing-clock detector timeout request |
| cmp_ok | input | 1 | Comparator output; low requests a reset |
| wdt_expire | input | 1 | Watchdog expiry request |
| flash_fault | input | 1 | Flash illegal-access request |
| reg_wr | input | 1 | Write strobe for the cause/enable register |
| reg_wdata | input | 8 | Write data (bit 2 missing-clock enable, bit 5 comparator enable) |
| reg_rdata | output | 8 | Cause flags of the last reset |
| sys_rst_n | output | 1 | Synchronous system reset, active low |
| wdt_tick | output | 1 | Watchdog time base, one pulse per 12 cycles |

## Verification
The assertions rely on the following conditions at the inputs:

- The four internal requests and the register strobe are synchronous to `clk`.
- `por_n` is the only asynchronous reset.
- The pin may change at any time, but it stays low for at least two cycles when it is meant to be seen.

The stimulus drives every input on the falling clock edge and holds each pin pulse for two or more cycles. It issues register writes only as single-cycle strobes, both inside and outside active resets. Simultaneous requests are driven on the same edge, so that the priority order can be observed.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_PIN = 0;
  localparam int BIT_MCD = 2;
  localparam int BIT_WDT = 3;
  localparam int BIT_CMP = 5;
  localparam int BIT_FLS = 6;

  typedef enum logic {ST_RUN = 1'b0, ST_HOLD = 1'b1} rst_state_e;

  typedef struct packed {
    logic pin;
    logic mcd;
    logic cmp;
    logic wdt;
    logic fls;
  } src_vec_t;

  function automatic logic [REG_W-1:0] cause_to_flags(input src_vec_t c);
    logic [REG_W-1:0] f;
    f = '0;
    f[BIT_PIN] = c.pin;
    f[BIT_MCD] = c.mcd;
    f[BIT_CMP] = c.cmp;
    f[BIT_WDT] = c.wdt;
    f[BIT_FLS] = c.fls;
    return f;
  endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_n = d_i;
    end else begin : g_many
      always_comb chain_n = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_arbiter.sv
module rstc_arbiter
  import rstc_pkg::*;
(
  input  logic     pin_low_i,
  input  logic     mcd_req_i,
  input  logic     mcd_en_i,
  input  logic     cmp_ok_i,
  input  logic     cmp_en_i,
  input  logic     wdt_req_i,
  input  logic     fls_req_i,
  output logic     any_req_o,
  output src_vec_t cause_o
);
  logic mcd_q, cmp_q;

  always_comb begin
    mcd_q = mcd_req_i & mcd_en_i;
    cmp_q = ~cmp_ok_i & cmp_en_i;
    cause_o     = '0;
    cause_o.pin = pin_low_i;
    cause_o.mcd = ~pin_low_i & mcd_q;
    cause_o.cmp = ~pin_low_i & ~mcd_q & cmp_q;
    cause_o.wdt = ~pin_low_i & ~mcd_q & ~cmp_q & wdt_req_i;
    cause_o.fls = ~pin_low_i & ~mcd_q & ~cmp_q & ~wdt_req_i & fls_req_i;
    any_req_o   = |cause_o;
  end
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch
  import rstc_pkg::*;
#(
  parameter int MIN_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic pin_low_i,
  output logic rst_out_n,
  output logic start_o,
  output logic release_o
);
  localparam int CNT_W = (MIN_CYCLES > 2) ? $clog2(MIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(MIN_CYCLES - 1);

  rst_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    start_o   = 1'b0;
    release_o = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (req_i) begin
          state_n = ST_HOLD;
          cnt_n   = LOAD;
          start_o = 1'b1;
        end
      end
      default: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (!pin_low_i) begin
          state_n   = ST_RUN;
          release_o = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= LOAD;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  assign rst_out_n = (state_q == ST_RUN);

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_low_i |=> !rst_out_n); // R1
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> (cnt_q == LOAD)); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !req_i) |=> rst_out_n); // R8
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_act_i,
  input  logic             start_i,
  input  logic             release_i,
  input  src_vec_t         cause_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] flags_o,
  output logic             mcd_en_o,
  output logic             cmp_en_o
);
  logic [REG_W-1:0] flags_q, flags_n;
  src_vec_t         pend_q, pend_n;
  logic             mcd_en_q, mcd_en_n;
  logic             cmp_en_q, cmp_en_n;
  logic             wr_ok;

  always_comb begin
    flags_n  = flags_q;
    pend_n   = pend_q;
    mcd_en_n = mcd_en_q;
    cmp_en_n = cmp_en_q;
    wr_ok    = wr_i & ~rst_act_i;
    if (wr_ok) begin
      mcd_en_n = wdata_i[BIT_MCD];
      cmp_en_n = wdata_i[BIT_CMP];
    end
    if (start_i) begin
      flags_n  = '0;
      pend_n   = cause_i;
      cmp_en_n = 1'b0;
    end
    if (release_i) begin
      flags_n = cause_to_flags(pend_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      pend_q   <= '0;
      mcd_en_q <= 1'b0;
      cmp_en_q <= 1'b0;
    end else begin
      flags_q  <= flags_n;
      pend_q   <= pend_n;
      mcd_en_q <= mcd_en_n;
      cmp_en_q <= cmp_en_n;
    end
  end

  assign flags_o  = flags_q;
  assign mcd_en_o = mcd_en_q;
  assign cmp_en_o = cmp_en_q;

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags_q)); // R9
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act_i |-> (flags_q == '0)); // R9
  AST_CMP_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act_i |-> !cmp_en_q); // R5
  AST_WRITE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !start_i && !release_i) |=> $stable(flags_q)); // R2
endmodule

// File: rtl/rstc_prescale.sv
module rstc_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!run_i)             cnt_n = '0;
    else if (cnt_q == LAST) cnt_n = '0;
    else                    cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick_o = run_i & (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R10
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (cnt_q == '0)); // R10
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int MIN_CYCLES  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int WDT_DIV     = 12
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             mcd_timeout,
  input  logic             cmp_ok,
  input  logic             wdt_expire,
  input  logic             flash_fault,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sys_rst_n,
  output logic             wdt_tick
);
  logic     pin_sync;
  logic     pin_low;
  logic     any_req;
  src_vec_t cause;
  logic     start_p, release_p;
  logic     mcd_en, cmp_en;

  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_pin_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d_i   (ext_rst_n),
    .q_o   (pin_sync)
  );

  assign pin_low = ~pin_sync;

  rstc_arbiter i_arb (
    .pin_low_i (pin_low),
    .mcd_req_i (mcd_timeout),
    .mcd_en_i  (mcd_en),
    .cmp_ok_i  (cmp_ok),
    .cmp_en_i  (cmp_en),
    .wdt_req_i (wdt_expire),
    .fls_req_i (flash_fault),
    .any_req_o (any_req),
    .cause_o   (cause)
  );

  rstc_stretch #(.MIN_CYCLES(MIN_CYCLES)) i_stretch (
    .clk       (clk),
    .rst_n     (por_n),
    .req_i     (any_req),
    .pin_low_i (pin_low),
    .rst_out_n (sys_rst_n),
    .start_o   (start_p),
    .release_o (release_p)
  );

  rstc_status i_status (
    .clk       (clk),
    .rst_n     (por_n),
    .rst_act_i (~sys_rst_n),
    .start_i   (start_p),
    .release_i (release_p),
    .cause_i   (cause),
    .wr_i      (reg_wr),
    .wdata_i   (reg_wdata),
    .flags_o   (reg_rdata),
    .mcd_en_o  (mcd_en),
    .cmp_en_o  (cmp_en)
  );

  rstc_prescale #(.DIV(WDT_DIV)) i_presc (
    .clk    (clk),
    .rst_n  (por_n),
    .run_i  (sys_rst_n),
    .tick_o (wdt_tick)
  );

  AST_MCD_GATED: assert property (@(posedge clk) disable iff (!por_n)
    cause.mcd |-> mcd_en); // R2
  AST_CMP_GATED: assert property (@(posedge clk) disable iff (!por_n)
    cause.cmp |-> cmp_en); // R4
  AST_TICK_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> !wdt_tick); // R10
endmodule

// File: tb/test_rstc_top.sv
module test_rstc_top;
  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, mcd_timeout, cmp_ok, wdt_expire, flash_fault;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sys_rst_n, wdt_tick;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [7:0] q_st[$];
  int         q_w[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  rstc_top i_rstc_top (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .mcd_timeout(mcd_timeout),
    .cmp_ok(cmp_ok), .wdt_expire(wdt_expire), .flash_fault(flash_fault),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst_n(sys_rst_n), .wdt_tick(wdt_tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_rst(input logic [7:0] st, input int w, input string tag);
    q_st.push_back(st);
    q_w.push_back(w);
    q_tag.push_back(tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d);
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  // monitor: pops one expected item per completed reset
  bit mon_en = 0;
  logic prev_rst = 1'b0;
  int low_cnt = 0;
  int tk_cnt = 0;
  bit tk_first = 0;
  int tick_bad = 0;
  int ticks_seen = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (!sys_rst_n) begin
        low_cnt++;
        if (wdt_tick) tick_bad++;
      end else if (!prev_rst) begin
        if (q_st.size() == 0) begin
          chk(0, "R8 unexpected reset", 1, 0);
        end else begin
          logic [7:0] st;
          int w;
          string tg;
          st = q_st.pop_front();
          w  = q_w.pop_front();
          tg = q_tag.pop_front();
          if (w >= 0) chk(low_cnt == w, {tg, " width"}, low_cnt, w);
          chk(reg_rdata == st, {tg, " cause"}, reg_rdata, st);
        end
        low_cnt  = 0;
        tk_cnt   = 0;
        tk_first = 1;
      end else begin
        tk_cnt++;
        if (wdt_tick) begin
          ticks_seen++;
          if (tk_cnt != (tk_first ? 11 : 12)) tick_bad++;
          tk_first = 0;
          tk_cnt   = 0;
        end
      end
      prev_rst = sys_rst_n;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1; mcd_timeout = 1'b0; cmp_ok = 1'b1;
    wdt_expire = 1'b0; flash_fault = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    cyc(3);
    chk(sys_rst_n == 1'b0, "R11 reset during por", sys_rst_n, 0);
    chk(reg_rdata == 8'h00, "R11 flags during por", reg_rdata, 0);
    chk(wdt_tick == 1'b0, "R10 tick during por", wdt_tick, 0);

    // R11: release after 16 edges
    expect_rst(8'h00, -1, "R11");
    mon_en = 1;
    por_n  = 1'b1;
    cyc(15);
    chk(sys_rst_n == 1'b0, "R11 held 15", sys_rst_n, 0);
    cyc(1);
    chk(sys_rst_n == 1'b1, "R11 release 16", sys_rst_n, 1);
    cyc(40);

    // R2: missing-clock disabled after power-on
    mcd_timeout = 1'b1; cyc(1); mcd_timeout = 1'b0;
    cyc(20);
    chk(sys_rst_n == 1'b1, "R2 mcd disabled no reset", sys_rst_n, 1);

    // R3: enable and trigger, then again (enable kept)
    reg_write(8'h04);
    expect_rst(8'h04, 16, "R3");
    mcd_timeout = 1'b1; cyc(1); mcd_timeout = 1'b0;
    cyc(25);
    expect_rst(8'h04, 16, "R3 kept");
    mcd_timeout = 1'b1; cyc(1); mcd_timeout = 1'b0;
    cyc(25);
    reg_write(8'h00);
    mcd_timeout = 1'b1; cyc(1); mcd_timeout = 1'b0;
    cyc(20);
    chk(reg_rdata == 8'h04, "R2 disabled after write 0", reg_rdata, 8'h04);

    // R1: long pin reset, then short pulse
    expect_rst(8'h01, 30, "R1 long");
    ext_rst_n = 1'b0; cyc(30); ext_rst_n = 1'b1;
    cyc(25);
    expect_rst(8'h01, 16, "R1 short");
    ext_rst_n = 1'b0; cyc(2); ext_rst_n = 1'b1;
    cyc(30);

    // R6 + R8: watchdog, flash fault during reset ignored
    expect_rst(8'h08, 16, "R6/R8");
    wdt_expire = 1'b1; cyc(1); wdt_expire = 1'b0;
    cyc(5);
    flash_fault = 1'b1; cyc(1); flash_fault = 1'b0;
    cyc(25);

    // R7
    expect_rst(8'h40, 16, "R7");
    flash_fault = 1'b1; cyc(1); flash_fault = 1'b0;
    cyc(25);

    // R4
    reg_write(8'h20);
    expect_rst(8'h20, 16, "R4");
    cmp_ok = 1'b0; cyc(1); cmp_ok = 1'b1;
    cyc(25);

    // R5: enable dropped by comparator reset
    cmp_ok = 1'b0; cyc(2); cmp_ok = 1'b1;
    cyc(20);
    chk(reg_rdata == 8'h20, "R5 disarmed after cmp reset", reg_rdata, 8'h20);
    // R5: enable dropped by watchdog reset
    reg_write(8'h20);
    expect_rst(8'h08, 16, "R5 wdt");
    wdt_expire = 1'b1; cyc(1); wdt_expire = 1'b0;
    cyc(25);
    cmp_ok = 1'b0; cyc(2); cmp_ok = 1'b1;
    cyc(20);
    chk(reg_rdata == 8'h08, "R5 disarmed after wdt reset", reg_rdata, 8'h08);

    // R9: priority
    reg_write(8'h24);
    expect_rst(8'h04, 16, "R9 mcd wins");
    mcd_timeout = 1'b1; cmp_ok = 1'b0; wdt_expire = 1'b1; flash_fault = 1'b1;
    cyc(1);
    mcd_timeout = 1'b0; cmp_ok = 1'b1; wdt_expire = 1'b0; flash_fault = 1'b0;
    cyc(5);
    chk(reg_rdata == 8'h00, "R9 flags zero in reset", reg_rdata, 0);
    cyc(20);
    reg_write(8'h20);
    expect_rst(8'h20, 16, "R9 cmp wins");
    cmp_ok = 1'b0; wdt_expire = 1'b1; flash_fault = 1'b1;
    cyc(1);
    cmp_ok = 1'b1; wdt_expire = 1'b0; flash_fault = 1'b0;
    cyc(25);
    expect_rst(8'h08, 16, "R9 wdt wins");
    wdt_expire = 1'b1; flash_fault = 1'b1;
    cyc(1);
    wdt_expire = 1'b0; flash_fault = 1'b0;
    cyc(5);
    // R2: write during reset ignored
    reg_write(8'h04);
    cyc(25);
    mcd_timeout = 1'b1; cyc(1); mcd_timeout = 1'b0;
    cyc(20);
    chk(reg_rdata == 8'h08, "R2 write in reset ignored", reg_rdata, 8'h08);

    chk(q_st.size() == 0, "R8 all expected resets seen", q_st.size(), 0);
    chk(tick_bad == 0 && ticks_seen > 10, "R10 tick spacing", tick_bad, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule